// File: doc/BRIEF.md
# Code Memory Lock Protection Unit

This block sits between the access requesters of an 8-bit microcontroller and its on-chip code memory. It enforces the protection selected by a set of one-time lock bits. Each lock bit is either unprogrammed or programmed. The highest programmed bit sets a cumulative protection level. Each higher level keeps every restriction of the levels below it and adds one more.

From that level, the block gates five kinds of access: programming, verify read-back, instruction fetch from internal code, table-lookup reads of internal code, and program execution from external memory.

The block also samples the external-access pin at the edge where reset is released. Once protection is active, it compares that held value against the live pin and raises a mismatch flag when they differ. While the mismatch is raised, the block withholds every grant that reads code memory.

With the default build, all outputs are registered. Each grant and the mismatch flag show the inputs of the previous clock cycle.

Top module: `lockguard_top`

## Requirements
- R1: While reset is sampled high at a clock edge, every grant and the mismatch flag are low after that edge, whatever the requests are.
- R2: With no lock bit programmed (`lock_prog` = 0), every request is granted and the mismatch flag stays low.
- R3: `lock_prog[i]` = 1 means lock bit i+1 is programmed. The level equals one plus the index of the highest programmed bit, or 0 when none is set. A pattern that skips a lower bit is treated fail-safe. For example, 3'b010 gives level 2 and 3'b100 gives level 3.
- R4: At level 1 or above, programming requests are refused.
- R5: At level 1 or above, a table-lookup read with `tbl_ext` = 1 (issued from external program memory) is refused. With `tbl_ext` = 0, the read is granted unless the mismatch flag is raised.
- R6: At level 2 or above, verify requests are refused.
- R7: At level 3, external execution fetches are refused. Below level 3 they are granted.
- R8: The external-access value is captured only at the first clock edge at which reset is sampled low after being high. Pin changes while reset is held, or after that edge, do not alter the held value.
- R9: The mismatch flag is high exactly when the level is 1 or above and the live pin differs from the held value. At level 0 it never rises.
- R10: A raised mismatch withholds the instruction-fetch and table-lookup grants. It has no effect on the program, verify and external-fetch grants.
- R11: A request changes its grant only at the next clock edge. An input change shows up at the outputs one cycle later, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_prog | input | NUM_LOCK | Lock bit states, 1 = programmed |
| ea_pin | input | 1 | Live external-access pin level |
| tbl_ext | input | 1 | Table-lookup read issued from external program memory |
| tbl_req | input | 1 | Table-lookup read request on internal code |
| ifetch_req | input | 1 | Instruction fetch request on internal code |
| prog_req | input | 1 | Byte programming request |
| verify_req | input | 1 | Verify read-back request |
| xfetch_req | input | 1 | External program execution request |
| tbl_gnt | output | 1 | Table-lookup read granted |
| ifetch_gnt | output | 1 | Instruction fetch granted |
| prog_gnt | output | 1 | Programming granted |
| verify_gnt | output | 1 | Verify granted |
| xfetch_gnt | output | 1 | External execution granted |
| ea_mismatch | output | 1 | Held external-access value differs from the live pin under protection |

## Verification
Every output is one register away from its inputs. So the bench drives a new input set at a falling edge, lets one rising edge pass, and compares all six outputs at the next falling edge against a model evaluated on the driven values.

The held external-access value comes into force on the same edge that first samples reset low. The model therefore takes the pin value of the reset-release cycle, and the first comparison after release already expects no mismatch for an unchanged pin.

A directed case samples just before the edge to show that a request is not yet granted in its own cycle.

// File: rtl/lockguard_pkg.sv
package lockguard_pkg;

   // One bit per access kind, shared by requests and grants
   typedef struct packed {
      logic tbl;
      logic ifetch;
      logic prog;
      logic verify;
      logic xfetch;
   } acc_t;

   localparam int ACC_W = $bits(acc_t);

endpackage

// File: rtl/lockguard_decode.sv
module lockguard_decode #(
   parameter int NUM_LOCK = 3,
   parameter int LVL_W    = $clog2(NUM_LOCK + 1)
) (
   input  logic [NUM_LOCK-1:0] lock_prog,
   output logic [LVL_W-1:0]    level
);

   // Ascending scan: the highest programmed bit wins, so a skipped
   // lower bit never lowers the level (fail-safe).
   always_comb begin
      level = '0;
      for (int i = 0; i < NUM_LOCK; i++) begin
         if (lock_prog[i]) level = LVL_W'(i + 1);
      end
   end

endmodule

// File: rtl/lockguard_ealatch.sv
module lockguard_ealatch (
   input  logic clk,
   input  logic rst,
   input  logic ea_pin,
   input  logic guard_on,
   output logic ea_mismatch
);

   logic rst_d;
   logic ea_q;
   logic ea_eff;

   always_ff @(posedge clk) begin
      rst_d <= rst;
   end

   // Held value has no reset: it is undefined until the first release
   always_ff @(posedge clk) begin
      if (rst_d && !rst) ea_q <= ea_pin;
   end

   // On the release edge itself the captured value is the live pin
   assign ea_eff      = rst_d ? ea_pin : ea_q;
   assign ea_mismatch = guard_on && (ea_eff != ea_pin);

endmodule

// File: rtl/lockguard_policy.sv
module lockguard_policy
   import lockguard_pkg::*;
#(
   parameter int LVL_W      = 2,
   parameter int TBL_LVL    = 1,
   parameter int PROG_LVL   = 1,
   parameter int VERIFY_LVL = 2,
   parameter int XFETCH_LVL = 3
) (
   input  logic [LVL_W-1:0] level,
   input  logic             tbl_ext,
   input  logic             mismatch,
   input  acc_t             req,
   output acc_t             gnt
);

   logic tbl_blk, prog_blk, ver_blk, xf_blk;

   assign tbl_blk  = tbl_ext && (level >= LVL_W'(TBL_LVL));
   assign prog_blk = level >= LVL_W'(PROG_LVL);
   assign ver_blk  = level >= LVL_W'(VERIFY_LVL);
   assign xf_blk   = level >= LVL_W'(XFETCH_LVL);

   always_comb begin
      gnt.tbl    = req.tbl && !tbl_blk && !mismatch;
      gnt.ifetch = req.ifetch && !mismatch;
      gnt.prog   = req.prog && !prog_blk;
      gnt.verify = req.verify && !ver_blk;
      gnt.xfetch = req.xfetch && !xf_blk;
   end

endmodule

// File: rtl/lockguard_top.sv
module lockguard_top
   import lockguard_pkg::*;
#(
   parameter int NUM_LOCK   = 3,
   parameter int TBL_LVL    = 1,
   parameter int PROG_LVL   = 1,
   parameter int VERIFY_LVL = 2,
   parameter int XFETCH_LVL = 3,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_LOCK-1:0] lock_prog,
   input  logic                ea_pin,
   input  logic                tbl_ext,
   input  logic                tbl_req,
   input  logic                ifetch_req,
   input  logic                prog_req,
   input  logic                verify_req,
   input  logic                xfetch_req,
   output logic                tbl_gnt,
   output logic                ifetch_gnt,
   output logic                prog_gnt,
   output logic                verify_gnt,
   output logic                xfetch_gnt,
   output logic                ea_mismatch
);

   localparam int LVL_W = $clog2(NUM_LOCK + 1);

   generate
      if (NUM_LOCK < 1 || NUM_LOCK > 7) begin : g_bad_num
         $error("NUM_LOCK must lie in 1..7");
      end
      if (TBL_LVL < 1 || TBL_LVL > NUM_LOCK || PROG_LVL < 1 || PROG_LVL > NUM_LOCK ||
          VERIFY_LVL < 1 || VERIFY_LVL > NUM_LOCK ||
          XFETCH_LVL < 1 || XFETCH_LVL > NUM_LOCK) begin : g_bad_lvl
         $error("every blocking level must lie in 1..NUM_LOCK");
      end
   endgenerate

   logic [LVL_W-1:0] level;
   logic             guard_on;
   logic             mm_raw;
   acc_t             req, gnt_raw;

   assign req = '{tbl: tbl_req, ifetch: ifetch_req, prog: prog_req,
                  verify: verify_req, xfetch: xfetch_req};

   lockguard_decode #(.NUM_LOCK(NUM_LOCK), .LVL_W(LVL_W)) u_decode (
      .lock_prog (lock_prog),
      .level     (level)
   );

   assign guard_on = level != '0;

   lockguard_ealatch u_ealatch (
      .clk         (clk),
      .rst         (rst),
      .ea_pin      (ea_pin),
      .guard_on    (guard_on),
      .ea_mismatch (mm_raw)
   );

   lockguard_policy #(
      .LVL_W(LVL_W), .TBL_LVL(TBL_LVL), .PROG_LVL(PROG_LVL),
      .VERIFY_LVL(VERIFY_LVL), .XFETCH_LVL(XFETCH_LVL)
   ) u_policy (
      .level    (level),
      .tbl_ext  (tbl_ext),
      .mismatch (mm_raw),
      .req      (req),
      .gnt      (gnt_raw)
   );

   acc_t gnt_o;
   logic mm_o;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               gnt_o <= '0;
               mm_o  <= 1'b0;
            end else begin
               gnt_o <= gnt_raw;
               mm_o  <= mm_raw;
            end
         end
      end else begin : g_comb
         assign gnt_o = rst ? '0 : gnt_raw;
         assign mm_o  = !rst && mm_raw;
      end
   endgenerate

   assign tbl_gnt     = gnt_o.tbl;
   assign ifetch_gnt  = gnt_o.ifetch;
   assign prog_gnt    = gnt_o.prog;
   assign verify_gnt  = gnt_o.verify;
   assign xfetch_gnt  = gnt_o.xfetch;
   assign ea_mismatch = mm_o;

endmodule

// File: rtl/lockguard_chk.sv
module lockguard_chk #(
   parameter int NUM_LOCK   = 3,
   parameter int TBL_LVL    = 1,
   parameter int PROG_LVL   = 1,
   parameter int VERIFY_LVL = 2,
   parameter int XFETCH_LVL = 3,
   parameter bit REG_OUT    = 1'b1
) (
   input logic                clk,
   input logic                rst,
   input logic [NUM_LOCK-1:0] lock_prog,
   input logic                tbl_ext,
   input logic                tbl_req,
   input logic                ifetch_req,
   input logic                prog_req,
   input logic                verify_req,
   input logic                xfetch_req,
   input logic                tbl_gnt,
   input logic                ifetch_gnt,
   input logic                prog_gnt,
   input logic                verify_gnt,
   input logic                xfetch_gnt,
   input logic                ea_mismatch
);

   logic                rst_q;
   logic [NUM_LOCK-1:0] lock_d;
   logic [5:0]          in_d;

   always_ff @(posedge clk) begin
      rst_q  <= rst;
      lock_d <= lock_prog;
      in_d   <= {tbl_ext, tbl_req, ifetch_req, prog_req, verify_req, xfetch_req};
   end

   // Inputs as seen by the outputs being checked
   logic [NUM_LOCK-1:0] lk;
   logic [5:0]          iv;
   assign lk = REG_OUT ? lock_d : lock_prog;
   assign iv = REG_OUT ? in_d
                       : {tbl_ext, tbl_req, ifetch_req, prog_req, verify_req, xfetch_req};

   always @(negedge clk) begin
      if (REG_OUT ? rst_q : rst) begin
         AST_RST_QUIET: assert (!tbl_gnt && !ifetch_gnt && !prog_gnt && !verify_gnt &&
                                !xfetch_gnt && !ea_mismatch) else $error("outputs active in reset"); // R1
      end
   end

   AST_PROG_LOCKED: assert property (@(posedge clk) disable iff (rst)
      prog_gnt |-> ((lk >> (PROG_LVL - 1)) == '0)); // R4
   AST_TBL_EXT_LOCKED: assert property (@(posedge clk) disable iff (rst)
      tbl_gnt |-> (!iv[5] || ((lk >> (TBL_LVL - 1)) == '0))); // R5
   AST_VERIFY_LOCKED: assert property (@(posedge clk) disable iff (rst)
      verify_gnt |-> ((lk >> (VERIFY_LVL - 1)) == '0)); // R6
   AST_XFETCH_LOCKED: assert property (@(posedge clk) disable iff (rst)
      xfetch_gnt |-> ((lk >> (XFETCH_LVL - 1)) == '0)); // R7
   AST_MM_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
      ea_mismatch |-> (lk != '0)); // R9
   AST_MM_INHIBIT: assert property (@(posedge clk) disable iff (rst)
      ea_mismatch |-> (!ifetch_gnt && !tbl_gnt)); // R10
   AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      (tbl_gnt || ifetch_gnt || prog_gnt || verify_gnt || xfetch_gnt) |->
      ((!tbl_gnt || iv[4]) && (!ifetch_gnt || iv[3]) && (!prog_gnt || iv[2]) &&
       (!verify_gnt || iv[1]) && (!xfetch_gnt || iv[0]))); // R11

endmodule

bind lockguard_top lockguard_chk #(
   .NUM_LOCK(NUM_LOCK), .TBL_LVL(TBL_LVL), .PROG_LVL(PROG_LVL),
   .VERIFY_LVL(VERIFY_LVL), .XFETCH_LVL(XFETCH_LVL), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst(rst), .lock_prog(lock_prog), .tbl_ext(tbl_ext),
   .tbl_req(tbl_req), .ifetch_req(ifetch_req), .prog_req(prog_req),
   .verify_req(verify_req), .xfetch_req(xfetch_req), .tbl_gnt(tbl_gnt),
   .ifetch_gnt(ifetch_gnt), .prog_gnt(prog_gnt), .verify_gnt(verify_gnt),
   .xfetch_gnt(xfetch_gnt), .ea_mismatch(ea_mismatch)
);

// File: tb/tb_lockguard_top.sv
module tb_lockguard_top;

   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] lock_prog = '0;
   logic       ea_pin = 1'b0, tbl_ext = 1'b0;
   logic       tbl_req = 1'b0, ifetch_req = 1'b0, prog_req = 1'b0;
   logic       verify_req = 1'b0, xfetch_req = 1'b0;
   logic       tbl_gnt, ifetch_gnt, prog_gnt, verify_gnt, xfetch_gnt, ea_mismatch;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;
   logic ea_model = 1'b0;
   logic prev_rst = 1'b1;

   always #(PERIOD/2) clk = ~clk;

   lockguard_top dut (
      .clk(clk), .rst(rst), .lock_prog(lock_prog), .ea_pin(ea_pin), .tbl_ext(tbl_ext),
      .tbl_req(tbl_req), .ifetch_req(ifetch_req), .prog_req(prog_req),
      .verify_req(verify_req), .xfetch_req(xfetch_req), .tbl_gnt(tbl_gnt),
      .ifetch_gnt(ifetch_gnt), .prog_gnt(prog_gnt), .verify_gnt(verify_gnt),
      .xfetch_gnt(xfetch_gnt), .ea_mismatch(ea_mismatch)
   );

   function automatic int lvl_of(input logic [2:0] lk);
      if (lk[2]) return 3;
      if (lk[1]) return 2;
      if (lk[0]) return 1;
      return 0;
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // Called at a falling edge: drive, pass one rising edge, compare
   task automatic step(input logic r, input logic [2:0] lk, input logic pin,
                       input logic te, input logic [4:0] rq);
      int  lv;
      logic mm, e_tbl, e_if, e_pg, e_vf, e_xf;
      rst = r; lock_prog = lk; ea_pin = pin; tbl_ext = te;
      {tbl_req, ifetch_req, prog_req, verify_req, xfetch_req} = rq;
      if (prev_rst && !r) ea_model = pin;   // R8 capture at release edge
      prev_rst = r;
      lv   = lvl_of(lk);
      mm   = (lv >= 1) && (pin != ea_model);
      e_tbl = rq[4] && !(te && lv >= 1) && !mm;
      e_if  = rq[3] && !mm;
      e_pg  = rq[2] && lv < 1;
      e_vf  = rq[1] && lv < 2;
      e_xf  = rq[0] && lv < 3;
      @(posedge clk);
      @(negedge clk);
      if (r) begin
         check("R1", tbl_gnt | ifetch_gnt | prog_gnt | verify_gnt | xfetch_gnt | ea_mismatch, 1'b0);
      end else begin
         check("R5", tbl_gnt, e_tbl);
         check("R10", ifetch_gnt, e_if);
         check("R4", prog_gnt, e_pg);
         check("R6", verify_gnt, e_vf);
         check("R7", xfetch_gnt, e_xf);
         check("R9", ea_mismatch, mm);
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      @(negedge clk);
      // R1: requests high during reset yield nothing
      step(1, 3'b000, 1'b0, 0, 5'b11111);
      step(1, 3'b000, 1'b1, 0, 5'b11111);
      // R8: pin toggled during reset; only the release-cycle value counts
      step(1, 3'b001, 1'b0, 0, 5'b00000);
      step(0, 3'b001, 1'b1, 0, 5'b11111);
      check("R8", ea_mismatch, 1'b0);
      step(0, 3'b001, 1'b0, 0, 5'b11111);
      check("R8", ea_mismatch, 1'b1);
      repeat (5) step(0, 3'b001, 1'b0, 0, 5'b01000);
      step(0, 3'b001, 1'b1, 0, 5'b01000);
      check("R8", ea_mismatch, 1'b0);      // held value still 1
      check("R10", ifetch_gnt, 1'b1);
      // R2: level 0, all granted even with pin mismatch
      step(0, 3'b000, 1'b0, 1, 5'b11111);
      check("R2", tbl_gnt & ifetch_gnt & prog_gnt & verify_gnt & xfetch_gnt, 1'b1);
      check("R2", ea_mismatch, 1'b0);
      // R3: skipped patterns are fail-safe
      step(0, 3'b010, 1'b1, 0, 5'b00111);
      check("R3", verify_gnt, 1'b0);
      check("R3", xfetch_gnt, 1'b1);
      step(0, 3'b100, 1'b1, 0, 5'b00111);
      check("R3", xfetch_gnt, 1'b0);
      check("R3", prog_gnt, 1'b0);
      // R5: internal table read allowed under lock
      step(0, 3'b011, 1'b1, 0, 5'b10000);
      check("R5", tbl_gnt, 1'b1);
      // R11: grant not visible in its own cycle
      step(0, 3'b000, 1'b1, 0, 5'b00000);
      prog_req = 1'b1; lock_prog = 3'b000;
      #1;
      check("R11", prog_gnt, 1'b0);
      @(posedge clk); @(negedge clk);
      check("R11", prog_gnt, 1'b1);
      // Constrained random with occasional resets
      for (int i = 0; i < 600; i++) begin
         logic r, pin;
         r   = ($urandom % 40) == 0;
         pin = (($urandom % 8) == 0) ? ~ea_pin : ea_pin;
         step(r, 3'($urandom), pin, 1'($urandom), 5'($urandom));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule